// File: doc/BRIEF.md
# Wrapping Double-to-Integer Converter

This block turns a 64-bit IEEE-754 binary64 operand into a 64-bit two's-complement integer. The rounding direction comes from a 2-bit mode input, and a chop input can force round-toward-zero. Results that do not fit are not clamped. The converter returns the low 64 bits of the scaled magnitude and reports integer overflow. Callers that want an unsigned conversion get it from the same operation, because a value in the range 2^63 to 2^64 keeps its bit pattern.

The converter is a two-stage pipeline.
- The first stage classifies the operand and aligns the significand against the binary point. It also captures the discarded bits in a round word.
- The second stage applies the rounding increment, restores the sign and registers the result together with three flags: invalid, integer overflow and inexact.

Trap dispatch is handled elsewhere. When flush-to-zero is asserted, subnormal inputs count as zero.

Top module: `f2i_wrap_cvt`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` is 0 and `out_value` and all three flags are 0.
- R2: Each accepted operand (`in_valid`=1) produces exactly one result, with `out_valid`=1 two clock edges later. Results keep the order of the inputs.
- R3: An operand with exponent field 0x7FF (infinity or NaN of either sign) yields value 0 with only `out_invalid` set.
- R4: An operand with exponent field 0 yields value 0 with no flags in two cases: the fraction is 0, or `in_flush`=1.
- R5: An operand with exponent field 0, a nonzero fraction and `in_flush`=0 is a magnitude below one half. It sets `out_inexact`. It yields 1 for a positive operand in mode 3, all-ones for a negative operand in mode 2, and 0 otherwise.
- R6: For a normal operand, the alignment shift is the exponent minus 1075. For a shift from 0 to 10 the value is the signed significand (hidden bit restored) shifted left, exact and with no flags.
- R7: For a shift of 11 or more, the value is the low 64 bits of the shifted significand (0 when the shift is 64 or more), with `out_int_ovf` and `out_inexact` set. The single exception is operand 0xC3E0000000000000: it yields 0x8000000000000000 and no flags.
- R8: For a negative shift, the integer part is rounded by mode. The encoding is: 0 = nearest-even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity. `out_inexact` is set exactly when a discarded bit is nonzero.
- R9: In mode 0, a discarded part of exactly one half rounds to the even integer. A discarded part above one half rounds away from zero.
- R10: `in_chop`=1 forces toward-zero rounding whatever `in_rmode` holds.
- R11: A set sign bit gives the two's-complement negation of the rounded magnitude.
- R12: `out_int_ovf` is never set without `out_inexact`. `out_invalid` is never set together with either of the other flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | binary64 operand |
| in_rmode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 minus inf, 3 plus inf) |
| in_chop | input | 1 | Force toward-zero rounding |
| in_flush | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result present this cycle |
| out_value | output | 64 | Two's-complement integer result |
| out_invalid | output | 1 | Operand was infinity or NaN |
| out_int_ovf | output | 1 | Integer did not fit in 64 signed bits |
| out_inexact | output | 1 | Result differs from the exact value |

## Verification
Every result, both the value and the three flags, is due two rising edges after its operand is sampled. The bench drives operands half a period before an edge and stamps each one with the cycle count. It compares outputs at the falling edge. An `out_valid` must match the oldest pending expectation, and that expectation must be exactly two cycles old. A result that comes early, late or unexpected counts as a failure of R2.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int DW        = 64;
    localparam int EW        = 11;
    localparam int FW        = 52;
    localparam int SIGW      = FW + 1;
    localparam int BIAS      = (1 << (EW - 1)) - 1;
    localparam int ALIGN_OFS = BIAS + FW;
    localparam int SAW       = $clog2(DW);
    localparam int SHW       = EW + 2;
    localparam int OVF_SHIFT = DW - SIGW;

    localparam logic [EW-1:0] EXP_ALL1 = '1;
    localparam logic [EW-1:0] EXP_MOSTNEG = EW'(BIAS + DW - 1);

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_DOWN    = 2'd2,
        RM_UP      = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_TINY,
        CLS_SPECIAL,
        CLS_NORMAL
    } opclass_e;

    typedef struct packed {
        opclass_e        cls;
        logic            sign;
        logic [EW-1:0]   expo;
        logic [SIGW-1:0] sig;
    } decoded_t;

    typedef struct packed {
        logic          sign;
        rmode_e        mode;
        logic [DW-1:0] mag;
        logic [DW-1:0] rnd;
        logic          inv;
        logic          iov;
    } aligned_t;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          inv;
        logic          iov;
        logic          ine;
    } result_t;

    function automatic rmode_e resolve_mode(input logic [1:0] req, input logic chop);
        return chop ? RM_ZERO : rmode_e'(req);
    endfunction

    function automatic logic is_half(input logic [DW-1:0] w);
        return w == {1'b1, {(DW-1){1'b0}}};
    endfunction

    function automatic logic above_half(input logic [DW-1:0] w);
        return w[DW-1] && (w[DW-2:0] != '0);
    endfunction

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
(
    input  logic [DW-1:0] operand,
    input  logic          flush,
    output decoded_t      dec
);
    logic [EW-1:0] e;
    logic [FW-1:0] f;

    always_comb begin
        e = operand[DW-2 -: EW];
        f = operand[FW-1:0];
        dec.sign = operand[DW-1];
        dec.expo = e;
        dec.sig  = {(e != '0), f};
        if (e == EXP_ALL1) begin
            dec.cls = CLS_SPECIAL;
        end else if (e == '0) begin
            // subnormal: sticky-only unless flushed
            dec.cls = ((f != '0) && !flush) ? CLS_TINY : CLS_ZERO;
        end else begin
            dec.cls = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  decoded_t dec,
    input  rmode_e   mode,
    output aligned_t al
);
    logic signed [SHW-1:0] shift;
    logic        [SHW-1:0] rshift;
    logic        [DW-1:0]  sig_w;
    logic        [SAW-1:0] back;
    logic                  mostneg;

    always_comb begin
        shift   = $signed({2'b00, dec.expo}) - $signed(SHW'(ALIGN_OFS));
        rshift  = SHW'(0) - SHW'(shift);
        sig_w   = {{(DW-SIGW){1'b0}}, dec.sig};
        // left shift that brings the dropped bits to the top of the round word
        back    = SAW'(0) - rshift[SAW-1:0];
        mostneg = dec.sign && (dec.expo == EXP_MOSTNEG)
                  && (dec.sig == {1'b1, {FW{1'b0}}});

        al.sign = dec.sign;
        al.mode = mode;
        al.mag  = '0;
        al.rnd  = '0;
        al.inv  = 1'b0;
        al.iov  = 1'b0;

        unique case (dec.cls)
            CLS_SPECIAL: al.inv = 1'b1;
            CLS_TINY:    al.rnd = DW'(1);
            CLS_ZERO:    al.rnd = '0;
            CLS_NORMAL: begin
                if (shift >= 0) begin
                    if (shift < $signed(SHW'(DW))) begin
                        al.mag = sig_w << shift[SAW-1:0];
                    end
                    if ((shift >= $signed(SHW'(OVF_SHIFT))) && !mostneg) begin
                        al.iov = 1'b1;
                    end
                end else if (rshift < SHW'(DW - 1)) begin
                    al.mag = sig_w >> rshift[SAW-1:0];
                    al.rnd = sig_w << back;
                end else begin
                    al.rnd = DW'(1);
                end
            end
            default: al.rnd = '0;
        endcase
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  aligned_t al,
    output result_t  res
);
    logic          lost;
    logic          incr;
    logic [DW-1:0] rounded;

    always_comb begin
        lost = (al.rnd != '0);
        incr = 1'b0;
        if (lost) begin
            unique case (al.mode)
                RM_NEAREST: incr = above_half(al.rnd) || (is_half(al.rnd) && al.mag[0]);
                RM_ZERO:    incr = 1'b0;
                RM_DOWN:    incr = al.sign;
                RM_UP:      incr = !al.sign;
                default:    incr = 1'b0;
            endcase
        end
        rounded   = al.mag + DW'(incr);
        res.value = al.sign ? (DW'(0) - rounded) : rounded;
        res.inv   = al.inv;
        res.iov   = al.iov;
        res.ine   = al.iov || lost;
    end
endmodule

// File: rtl/f2i_wrap_cvt.sv
module f2i_wrap_cvt
    import f2i_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [63:0]   in_operand,
    input  logic [1:0]    in_rmode,
    input  logic          in_chop,
    input  logic          in_flush,
    output logic          out_valid,
    output logic [63:0]   out_value,
    output logic          out_invalid,
    output logic          out_int_ovf,
    output logic          out_inexact
);
    decoded_t dec;
    aligned_t al_c, al_q;
    result_t  res_c, res_q;
    logic     s1_valid, s2_valid;

    f2i_classify u_cls (
        .operand (in_operand),
        .flush   (in_flush),
        .dec     (dec)
    );

    f2i_align u_aln (
        .dec  (dec),
        .mode (resolve_mode(in_rmode, in_chop)),
        .al   (al_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            al_q     <= '0;
        end else begin
            s1_valid <= in_valid;
            al_q     <= in_valid ? al_c : '0;
        end
    end

    f2i_round u_rnd (
        .al  (al_q),
        .res (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            res_q    <= '0;
        end else begin
            s2_valid <= s1_valid;
            res_q    <= s1_valid ? res_c : '0;
        end
    end

    assign out_valid   = s2_valid;
    assign out_value   = res_q.value;
    assign out_invalid = res_q.inv;
    assign out_int_ovf = res_q.iov;
    assign out_inexact = res_q.ine;
endmodule

// File: rtl/f2i_wrap_cvt_chk.sv
module f2i_wrap_cvt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_operand,
    input logic        out_valid,
    input logic [63:0] out_value,
    input logic        out_invalid,
    input logic        out_int_ovf,
    input logic        out_inexact
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: one result per operand, two edges later
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R3: non-finite operand gives invalid two edges later
    a_r3_special_invalid: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd2) && $past(in_valid, 2) && ($past(in_operand[62:52], 2) == 11'h7FF))
        |-> out_invalid);

    // R3: invalid result is zero
    a_r3_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_value == 64'd0));

    // R12: overflow implies inexact
    a_r12_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
        out_int_ovf |-> out_inexact);

    // R12: invalid stands alone
    a_r12_invalid_alone: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (!out_int_ovf && !out_inexact));

    // R1: no flags without a result
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ({out_invalid, out_int_ovf, out_inexact} == 3'b000));
endmodule

bind f2i_wrap_cvt f2i_wrap_cvt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .out_valid   (out_valid),
    .out_value   (out_value),
    .out_invalid (out_invalid),
    .out_int_ovf (out_int_ovf),
    .out_inexact (out_inexact)
);

// File: tb/test_f2i_wrap_cvt.sv
module test_f2i_wrap_cvt;

    typedef struct {
        logic [63:0] val;
        logic        inv;
        logic        iov;
        logic        ine;
        int          stamp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_chop = 1'b0;
    logic        in_flush = 1'b0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_invalid, out_int_ovf, out_inexact;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    f2i_wrap_cvt i_f2i_wrap_cvt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_rmode(in_rmode), .in_chop(in_chop), .in_flush(in_flush),
        .out_valid(out_valid), .out_value(out_value), .out_invalid(out_invalid),
        .out_int_ovf(out_int_ovf), .out_inexact(out_inexact)
    );

    function automatic exp_t model(logic [63:0] op, logic [1:0] rm, logic chop, logic fl);
        exp_t r;
        logic [10:0]  e = op[62:52];
        logic         s = op[63];
        logic [63:0]  sig = {11'd0, 1'b1, op[51:0]};
        logic [127:0] wide;
        logic [63:0]  mag = '0, rem = '0, half = '0;
        logic         lost = 1'b0, inc = 1'b0;
        int           mode = chop ? 1 : int'(rm);
        int           sh, n;
        r.val = '0; r.inv = 0; r.iov = 0; r.ine = 0; r.stamp = 0; r.tag = "";
        if (e == 11'h7FF) begin
            r.inv = 1; return r;
        end
        if (e == 0) begin
            if (op[51:0] == 0 || fl) return r;
            lost = 1; rem = 64'd1; half = 64'hFFFF_FFFF_FFFF_FFFF;
        end else begin
            sh = int'(e) - 1075;
            if (sh >= 0) begin
                wide = {64'd0, sig} << sh;
                mag = (sh < 64) ? wide[63:0] : 64'd0;
                if (sh >= 11 && op != 64'hC3E0_0000_0000_0000) begin
                    r.iov = 1; r.ine = 1;
                end
            end else begin
                n = -sh;
                if (n >= 64) begin
                    lost = 1; rem = 64'd1; half = 64'hFFFF_FFFF_FFFF_FFFF;
                end else begin
                    mag  = sig >> n;
                    rem  = sig & ((64'd1 << n) - 64'd1);
                    half = 64'd1 << (n - 1);
                    lost = (rem != 0);
                end
            end
        end
        if (lost) begin
            r.ine = 1;
            case (mode)
                0: inc = (rem > half) || (rem == half && mag[0]);
                2: inc = s;
                3: inc = !s;
                default: inc = 0;
            endcase
        end
        mag = mag + {63'd0, inc};
        r.val = s ? -mag : mag;
        return r;
    endfunction

    function automatic string auto_tag(logic [63:0] op, logic fl);
        int sh;
        if (op[62:52] == 11'h7FF) return "R3";
        if (op[62:52] == 0) return (op[51:0] == 0 || fl) ? "R4" : "R5";
        sh = int'(op[62:52]) - 1075;
        if (sh >= 11) return "R7";
        if (sh >= 0) return "R6";
        return op[63] ? "R11" : "R8";
    endfunction

    task automatic check_out();
        exp_t x;
        if (out_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected result: actual valid=1 expected valid=0");
            end else begin
                x = q.pop_front();
                if (cyc != x.stamp + 2) begin
                    fails++;
                    $display("FAIL R2 latency: actual %0d expected %0d", cyc - x.stamp, 2);
                end
                if (out_value !== x.val || out_invalid !== x.inv ||
                    out_int_ovf !== x.iov || out_inexact !== x.ine) begin
                    fails++;
                    $display("FAIL %s: actual %h inv=%b iov=%b ine=%b expected %h inv=%b iov=%b ine=%b",
                             x.tag, out_value, out_invalid, out_int_ovf, out_inexact,
                             x.val, x.inv, x.iov, x.ine);
                end
            end
        end else if (q.size() != 0 && cyc > q[0].stamp + 2) begin
            checks++; fails++;
            $display("FAIL R2 missing result: actual valid=0 expected valid=1");
            void'(q.pop_front());
        end
    endtask

    task automatic step(logic v, logic [63:0] op, logic [1:0] rm, logic ch, logic fl, string tag);
        exp_t x;
        @(negedge clk);
        cyc++;
        check_out();
        in_valid = v; in_operand = op; in_rmode = rm; in_chop = ch; in_flush = fl;
        if (v) begin
            x = model(op, rm, ch, fl);
            x.stamp = cyc;
            x.tag = (tag == "") ? auto_tag(op, fl) : tag;
            q.push_back(x);
        end
    endtask

    task automatic all_modes(logic [63:0] op, string tag);
        for (int m = 0; m < 4; m++) step(1'b1, op, 2'(m), 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] op;
        logic [10:0] e;
        int          dummy;
        dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_value !== '0 || {out_invalid, out_int_ovf, out_inexact} !== 3'b000) begin
            fails++;
            $display("FAIL R1 reset: actual v=%b %h expected v=0 0", out_valid, out_value);
        end
        @(negedge clk); rst = 1'b0;
        checks++;
        if (out_valid !== 1'b0 || out_value !== '0) begin
            fails++;
            $display("FAIL R1 after release: actual v=%b %h expected v=0 0", out_valid, out_value);
        end

        // R3 specials
        step(1, 64'h7FF8_0000_0000_0000, 0, 0, 0, "R3");
        step(1, 64'hFFF0_0000_0000_0000, 3, 0, 0, "R3");
        // R4 zeros and flushed subnormals
        step(1, 64'h0000_0000_0000_0000, 3, 0, 0, "R4");
        step(1, 64'h8000_0000_0000_0000, 2, 0, 0, "R4");
        step(1, 64'h8000_0000_0000_0001, 2, 0, 1, "R4");
        // R5 smallest subnormal, both signs, every mode
        all_modes(64'h0000_0000_0000_0001, "R5");
        all_modes(64'h8000_0000_0000_0001, "R5");
        // R6 exact left shifts
        step(1, 64'h4330_0000_0000_0000, 0, 0, 0, "R6");
        step(1, 64'h43D0_0000_0000_0001, 1, 0, 0, "R6");
        // R7 overflow wrap and the most-negative exemption
        step(1, 64'h43E0_0000_0000_0000, 0, 0, 0, "R7");
        step(1, 64'hC3E0_0000_0000_0000, 0, 0, 0, "R7");
        step(1, 64'hC3E0_0000_0000_0001, 0, 0, 0, "R7");
        step(1, 64'h43F0_0000_0000_0000, 0, 0, 0, "R7");
        step(1, 64'h7FE0_0000_0000_0000, 0, 0, 0, "R7");
        // R8 / R9 / R11 halves and ties
        all_modes(64'h3FE0_0000_0000_0000, "R9");
        all_modes(64'hBFE0_0000_0000_0000, "R11");
        all_modes(64'h3FF8_0000_0000_0000, "R9");
        all_modes(64'hBFF8_0000_0000_0000, "R11");
        all_modes(64'h4004_0000_0000_0000, "R9");
        all_modes(64'h3FF4_0000_0000_0000, "R8");
        step(1, 64'h3FE8_0000_0000_0000, 0, 0, 0, "R9");
        // R10 chop overrides every mode
        for (int m = 0; m < 4; m++) step(1, 64'hBFF8_0000_0000_0000, 2'(m), 1, 0, "R10");
        for (int m = 0; m < 4; m++) step(1, 64'h3FFC_0000_0000_0000, 2'(m), 1, 0, "R10");

        // random mix with bubbles
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 8)
                0: e = 11'($urandom);
                1: e = ($urandom % 2) ? 11'h7FF : 11'h000;
                default: e = 11'(1075 - 70 + ($urandom % 90));
            endcase
            op = {1'($urandom), e, 20'($urandom), 32'($urandom)};
            if ($urandom % 5 == 0) op[51:0] = '0;
            if ($urandom % 6 == 0) step(0, '0, 0, 0, 0, "");
            step(1, op, 2'($urandom), ($urandom % 7) == 0, ($urandom % 4) == 0, "");
        end
        repeat (4) step(0, '0, 0, 0, 0, "");
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 drain: actual %0d pending expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule